// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Interface Engine

This block moves bytes over a four-wire SPI link, either as the clock-owning master or as a selected slave. A single mode bit in its configuration register picks the role, and two more bits set the idle level of the serial clock and the edge on which data is captured. A simple strobe interface lets the host do four things: write a transmit byte, write the configuration, write a clock divider, and acknowledge the received byte. An 8-bit status word shows the configuration together with live flags.

In master mode, writing a byte while the engine is idle starts a transfer. The engine drives the clock, data out and an active-low select. Each half period of the clock lasts (divider+1) system clocks. The engine captures the returning data on the last system clock of each bit. In slave mode, the clock, data in and select pins pass through synchronizers first. The select pin is also filtered against glitches. A transmit byte loads into the shift register before or between frames, and the received byte waits in a buffer until the host acknowledges it.

Top module: `spi_engine`

## Requirements
- R1: After reset, with nss_i high, the status word reads 0x07, rx_data reads 0, wcol is 0, sck_o is 0 and nss_o is 1.
- R2: A configuration write made while idle loads status bits 6 (master mode), 5 (phase) and 4 (polarity) from host_wdata[6:4]. Bits 7 and 3..0 ignore the write. A configuration write made while busy has no effect.
- R3: In master mode, a transmit write while idle raises busy (bit 7) and drives nss_o low for exactly 16*(div+1) system clocks. Busy never rises without a transmit write.
- R4: sck_o rests at the polarity bit whenever the master is idle. Data goes out MSB first and holds steady on the capture edge. With phase 0 the capture edge is the first edge of each bit. With phase 1 it is the second edge.
- R5: The master captures miso_i on the final system clock of each bit, MSB first. With miso_i looped back to mosi_o, rx_data equals the byte sent.
- R6: A master-mode transmit write made while busy is discarded, and the wcol output goes to 1. An idle configuration write returns wcol to 0.
- R7: In master mode, status bits 1 (shift register empty) and 0 (receive buffer empty) always read 1.
- R8: In slave mode, the engine captures mosi_i MSB first on the capture edge. After 8 bits, rx_data holds the byte and bit 0 reads 0. One rx_re pulse returns bit 0 to 1.
- R9: In slave mode, a buffered transmit byte loads into the shift register and drops bit 1 to 0. It then appears on miso_o MSB first, under either phase. Bit 1 returns to 1 when a frame ends with nothing pending.
- R10: Status bit 2 follows nss_i at once. Status bit 3 (selected) rises only after nss_i has stayed low for three filtered samples, so a low pulse two clocks long never sets it.
- R11: In slave mode, busy is 1 from the first clock edge of a frame and clears when the frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_we | input | 1 | Transmit byte write strobe |
| cfg_we | input | 1 | Configuration write strobe |
| div_we | input | 1 | Clock divider write strobe |
| rx_re | input | 1 | Receive byte read acknowledge |
| host_wdata | input | 8 | Host write data |
| rx_data | output | 8 | Last received byte |
| status | output | 8 | Configuration and status word |
| wcol | output | 1 | Sticky write-collision flag |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| nss_o | output | 1 | Master select, active low |
| sck_i | input | 1 | Slave serial clock in |
| mosi_i | input | 1 | Slave data in |
| miso_i | input | 1 | Master data in |
| nss_i | input | 1 | Slave select in, active low |
| miso_o | output | 1 | Slave data out |

## Verification
The hardest case to reach from the ports is slave-mode transmit under both phases. The MSB has to be presented before any clock edge with phase 0, but only on the first leading edge with phase 1. The frame also has to complete at a different edge in each case. The bench plays the remote master itself. It holds every half period for several system clocks so the synchronized edges settle, and it samples miso_o on its own capture edge. Glitch rejection is reached by a select pulse shorter than the filter depth.

// File: rtl/spi_engine_pkg.sv
// Shared definitions for the SPI engine: status word bit positions and the
// configuration record. Assumes an 8-bit status word.
package spi_engine_pkg;
    localparam int ST_W    = 8;
    localparam int ST_BUSY = 7;
    localparam int ST_MEN  = 6;
    localparam int ST_CPHA = 5;
    localparam int ST_CPOL = 4;
    localparam int ST_SEL  = 3;
    localparam int ST_NSS  = 2;
    localparam int ST_SRMT = 1;
    localparam int ST_RXE  = 0;

    typedef struct packed {
        logic men;
        logic cpha;
        logic cpol;
    } spi_cfg_t;
endpackage

// File: rtl/spi_engine_sync.sv
// Multi-flop synchronizer for one asynchronous input.
// Assumes STAGES >= 2. The reset value is chosen by the instantiating module.
module spi_engine_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_engine_nss_filter.sv
// Select-pin deglitcher: a synchronizer, then a filter that changes the
// output only after FILT_LEN equal samples in a row.
// Assumes FILT_LEN >= 2. The pin is active low and idles high.
module spi_engine_nss_filter #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nss_pin,
    output logic selected
);
    logic                nss_s;
    logic [FILT_LEN-1:0] hist;
    logic                filt;

    spi_engine_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(nss_pin), .q(nss_s)
    );

    // record recent samples and update the filtered level once they agree
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '1;
            filt <= 1'b1;
        end else begin
            hist <= {hist[FILT_LEN-2:0], nss_s};
            if (&hist)       filt <= 1'b1;
            else if (~|hist) filt <= 1'b0;
        end
    end

    assign selected = ~filt;
endmodule

// File: rtl/spi_engine_master.sv
// Master shifter. It drives SCK, MOSI and an active-low select, with a half
// period of (div+1) system clocks, and captures MISO on the last system clock
// of each bit. Assumes start is pulsed only while the engine is idle.
module spi_engine_master #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              miso_i,
    output logic              busy,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              nss_o,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [DIV_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitcnt;
    logic              half;

    // step the half-period counter, shift bits and capture the finished byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            shreg   <= '0;
            cnt     <= '0;
            bitcnt  <= '0;
            half    <= 1'b0;
            rx_byte <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                shreg  <= tx_byte;
                cnt    <= '0;
                bitcnt <= '0;
                half   <= 1'b0;
            end
        end else if (cnt == div) begin
            cnt <= '0;
            if (!half) begin
                half <= 1'b1;
            end else begin
                half <= 1'b0;
                if (bitcnt == LAST_BIT) begin
                    busy    <= 1'b0;
                    rx_byte <= {shreg[DATA_W-2:0], miso_i};
                end else begin
                    shreg  <= {shreg[DATA_W-2:0], miso_i};
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sck_o  = busy ? (cpol ^ half ^ cpha) : cpol;
    assign mosi_o = shreg[DATA_W-1];
    assign nss_o  = ~busy;
endmodule

// File: rtl/spi_engine_slave.sv
// Slave shifter. It works on synchronized SCK/MOSI and the filtered select,
// holds a one-byte transmit buffer and a one-byte receive buffer, and keeps
// the shift-register-empty and receive-empty flags.
// Assumes each SCK half period lasts several system clocks.
module spi_engine_slave #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              selected,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_re,
    output logic              busy,
    output logic              srmt,
    output logic              rx_empty,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso_o
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic              sck_q;
    logic              edge_e, lead_e, trail_e, sample_e, shift_e;
    logic              complete, load_idle;
    logic [DATA_W-1:0] tx_buf, tx_sh, rx_sh;
    logic              tx_full, primed;
    logic [BIT_W-1:0]  idx, rcnt;

    // remember the previous synchronized clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign edge_e    = active && selected && (sck_s != sck_q);
    assign lead_e    = edge_e && (sck_s != cpol);
    assign trail_e   = edge_e && (sck_s == cpol);
    assign sample_e  = cpha ? trail_e : lead_e;
    assign shift_e   = cpha ? lead_e : trail_e;
    assign complete  = cpha ? (sample_e && rcnt == LAST_BIT)
                            : (shift_e && idx == LAST_BIT);
    assign load_idle = active && !busy && srmt && tx_full && !edge_e;

    // hold the host's transmit byte until the shift register takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else if (tx_we && active) begin
            tx_buf  <= tx_byte;
            tx_full <= 1'b1;
        end else if (load_idle || (complete && tx_full)) begin
            tx_full <= 1'b0;
        end
    end

    // latch a completed byte and clear the empty flag until the host reads it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            rx_empty <= 1'b1;
        end else if (sample_e && rcnt == LAST_BIT) begin
            rx_byte  <= {rx_sh[DATA_W-2:0], mosi_s};
            rx_empty <= 1'b0;
        end else if (rx_re) begin
            rx_empty <= 1'b1;
        end
    end

    // frame sequencing: bit counters, shift register loads and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            idx    <= '0;
            rcnt   <= '0;
            primed <= 1'b0;
            busy   <= 1'b0;
            srmt   <= 1'b1;
        end else if (!active || !selected) begin
            idx    <= '0;
            rcnt   <= '0;
            primed <= 1'b0;
            busy   <= 1'b0;
            if (busy) begin
                srmt  <= 1'b1;
                tx_sh <= '0;
            end else if (load_idle) begin
                tx_sh <= tx_buf;
                srmt  <= 1'b0;
            end
        end else begin
            if (edge_e) begin
                busy <= 1'b1;
                srmt <= 1'b0;
            end
            if (sample_e) begin
                rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
                rcnt  <= (rcnt == LAST_BIT) ? '0 : rcnt + 1'b1;
            end
            if (shift_e) begin
                if (cpha && !primed)    primed <= 1'b1;
                else if (idx != LAST_BIT) idx  <= idx + 1'b1;
            end
            if (complete) begin
                busy   <= 1'b0;
                idx    <= '0;
                primed <= 1'b0;
                if (tx_full) begin
                    tx_sh <= tx_buf;
                    srmt  <= 1'b0;
                end else begin
                    tx_sh <= '0;
                    srmt  <= 1'b1;
                end
            end else if (load_idle) begin
                tx_sh <= tx_buf;
                srmt  <= 1'b0;
            end
        end
    end

    assign miso_o = (active && selected) ? tx_sh[LAST_BIT - idx] : 1'b0;
endmodule

// File: rtl/spi_engine.sv
// SPI engine top. It holds the configuration, divider and collision flag,
// selects the master or slave shifter by the mode bit, and builds the
// status word. Assumes DATA_W = 8 (status and configuration share the host
// bus) and DIV_W <= DATA_W.
module spi_engine
    import spi_engine_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 8,
    parameter int SYNC_N   = 2,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_we,
    input  logic              cfg_we,
    input  logic              div_we,
    input  logic              rx_re,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] rx_data,
    output logic [ST_W-1:0]   status,
    output logic              wcol,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              nss_o,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              miso_i,
    input  logic              nss_i,
    output logic              miso_o
);
    spi_cfg_t          cfg_q;
    logic [DIV_W-1:0]  div_q;
    logic              m_busy, s_busy, busy_any, start;
    logic              s_srmt, s_rxe, selected;
    logic              sck_s, mosi_s;
    logic [DATA_W-1:0] m_rx, s_rx;

    assign busy_any = cfg_q.men ? m_busy : s_busy;
    assign start    = tx_we && cfg_q.men && !m_busy;

    // configuration and divider writes, accepted only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            div_q <= '0;
        end else if (!busy_any) begin
            if (cfg_we) begin
                cfg_q.men  <= host_wdata[ST_MEN];
                cfg_q.cpha <= host_wdata[ST_CPHA];
                cfg_q.cpol <= host_wdata[ST_CPOL];
            end
            if (div_we) div_q <= host_wdata[DIV_W-1:0];
        end
    end

    // sticky collision flag: set by a master write while busy, cleared by an idle config write
    always_ff @(posedge clk) begin
        if (!rst_n)                            wcol <= 1'b0;
        else if (tx_we && cfg_q.men && m_busy) wcol <= 1'b1;
        else if (cfg_we && !busy_any)          wcol <= 1'b0;
    end

    spi_engine_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s)
    );
    spi_engine_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_mosi_sync (
        .clk(clk), .rst_n(rst_n), .d(mosi_i), .q(mosi_s)
    );

    spi_engine_nss_filter #(.STAGES(SYNC_N), .FILT_LEN(FILT_LEN)) u_nss (
        .clk(clk), .rst_n(rst_n), .nss_pin(nss_i), .selected(selected)
    );

    spi_engine_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_master (
        .clk(clk), .rst_n(rst_n), .cpol(cfg_q.cpol), .cpha(cfg_q.cpha),
        .div(div_q), .start(start), .tx_byte(host_wdata), .miso_i(miso_i),
        .busy(m_busy), .sck_o(sck_o), .mosi_o(mosi_o), .nss_o(nss_o),
        .rx_byte(m_rx)
    );

    spi_engine_slave #(.DATA_W(DATA_W)) u_slave (
        .clk(clk), .rst_n(rst_n), .active(!cfg_q.men), .cpol(cfg_q.cpol),
        .cpha(cfg_q.cpha), .selected(selected), .sck_s(sck_s),
        .mosi_s(mosi_s), .tx_we(tx_we), .tx_byte(host_wdata), .rx_re(rx_re),
        .busy(s_busy), .srmt(s_srmt), .rx_empty(s_rxe), .rx_byte(s_rx),
        .miso_o(miso_o)
    );

    assign rx_data = cfg_q.men ? m_rx : s_rx;

    // assemble the status word; the slave flags read 1 in master mode
    always_comb begin
        status          = '0;
        status[ST_BUSY] = busy_any;
        status[ST_MEN]  = cfg_q.men;
        status[ST_CPHA] = cfg_q.cpha;
        status[ST_CPOL] = cfg_q.cpol;
        status[ST_SEL]  = selected;
        status[ST_NSS]  = nss_i;
        status[ST_SRMT] = cfg_q.men | s_srmt;
        status[ST_RXE]  = cfg_q.men | s_rxe;
    end
endmodule

// File: rtl/spi_engine_checker.sv
// Property checker for spi_engine, attached through bind. It watches only
// top-level ports of the engine.
module spi_engine_checker
    import spi_engine_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [ST_W-1:0] status,
    input logic            tx_we,
    input logic            wcol,
    input logic            sck_o,
    input logic            nss_o
);
    // idle master clock rests at the polarity bit (R4)
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_MEN] && !status[ST_BUSY]) |-> (sck_o == status[ST_CPOL]));

    // master select is low exactly while the master is busy (R3)
    p_nss_tracks_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_MEN] |-> (nss_o == !status[ST_BUSY]));

    // master busy only rises after a transmit write (R3)
    p_start_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[ST_BUSY]) && status[ST_MEN]) |-> $past(tx_we));

    // slave-only flags read 1 in master mode (R7)
    p_master_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_MEN] |-> (status[ST_SRMT] && status[ST_RXE]));

    // a write during a master transfer raises the collision flag (R6)
    p_wcol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we && status[ST_MEN] && status[ST_BUSY]) |=> wcol);

    // configuration bits hold while a transfer runs (R2)
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_BUSY] |=> $stable(status[ST_MEN:ST_CPOL]));
endmodule

bind spi_engine spi_engine_checker u_chk (
    .clk(clk), .rst_n(rst_n), .status(status), .tx_we(tx_we),
    .wcol(wcol), .sck_o(sck_o), .nss_o(nss_o)
);

// File: tb/spi_engine_bench.sv
module spi_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_we = 1'b0, cfg_we = 1'b0, div_we = 1'b0, rx_re = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] rx_data, status;
    logic       wcol, sck_o, mosi_o, nss_o, miso_o;
    logic       sck_i = 1'b0, mosi_i = 1'b0, nss_i = 1'b1;
    logic       loop_en = 1'b1;
    logic       miso_i;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign miso_i = loop_en ? mosi_o : 1'b0;

    spi_engine u_spi_engine (
        .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .cfg_we(cfg_we),
        .div_we(div_we), .rx_re(rx_re), .host_wdata(host_wdata),
        .rx_data(rx_data), .status(status), .wcol(wcol), .sck_o(sck_o),
        .mosi_o(mosi_o), .nss_o(nss_o), .sck_i(sck_i), .mosi_i(mosi_i),
        .miso_i(miso_i), .nss_i(nss_i), .miso_o(miso_o)
    );

    // master MOSI monitor: capture on the phase-selected edge
    logic       mon_en = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
    logic [7:0] mon_sh = 8'h00;
    int         mon_cnt = 0;
    always @(sck_o) begin
        if (mon_en && (((sck_o != mon_cpol) ? 1'b1 : 1'b0) ^ mon_cpha)) begin
            mon_sh  = {mon_sh[6:0], mosi_o};
            mon_cnt = mon_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int kind, input logic [7:0] d);
        @(negedge clk);
        host_wdata = d;
        case (kind)
            0: tx_we  = 1'b1;
            1: cfg_we = 1'b1;
            2: div_we = 1'b1;
            default: rx_re = 1'b1;
        endcase
        @(negedge clk);
        tx_we = 1'b0; cfg_we = 1'b0; div_we = 1'b0; rx_re = 1'b0;
    endtask

    task automatic set_cfg(input logic men, input logic cpha, input logic cpol);
        pulse(1, {1'b0, men, cpha, cpol, 4'b0000});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // bench acts as remote master: drive sck_i/mosi_i, sample miso_o
    localparam int SH = 6;
    task automatic slave_xfer(input logic [7:0] mo, input logic cpol, input logic cpha,
                              output logic [7:0] got, output logic mid_busy);
        got = 8'h00;
        mid_busy = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            if (!cpha) begin
                mosi_i = mo[b];
                idle(SH);
                got = {got[6:0], miso_o};
                sck_i = ~cpol;
                idle(SH);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol;
                mosi_i = mo[b];
                idle(SH);
                got = {got[6:0], miso_o};
                sck_i = cpol;
                idle(SH);
            end
            if (b == 4) mid_busy = status[7];
        end
    endtask

    // master vectors: {tx byte, divider, polarity, phase}
    localparam int NV = 6;
    localparam logic [17:0] VEC [NV] = '{
        {8'hA5, 8'd0, 1'b0, 1'b0},
        {8'h3C, 8'd1, 1'b0, 1'b1},
        {8'h81, 8'd2, 1'b1, 1'b0},
        {8'h5E, 8'd0, 1'b1, 1'b1},
        {8'hFF, 8'd3, 1'b0, 1'b0},
        {8'h00, 8'd1, 1'b1, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic       mb;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 status", status, 8'h07);
        check("R1 rx_data", rx_data, 8'h00);
        check("R1 wcol", wcol, 1'b0);
        check("R1 sck_o", sck_o, 1'b0);
        check("R1 nss_o", nss_o, 1'b1);

        // R2 configuration write and read-only bits
        pulse(1, 8'h70);
        check("R2 cfg readback", status, 8'h77);
        check("R4 idle high", sck_o, 1'b1);
        pulse(1, 8'h8F);
        check("R2 read-only bits", status, 8'h07);

        // table of master transfers, looped back
        loop_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [7:0] tx, dv;
            logic       pol, pha;
            int         n;
            {tx, dv, pol, pha} = VEC[v];
            set_cfg(1'b1, pha, pol);
            pulse(2, dv);
            check("R4 idle level", sck_o, pol);
            mon_cpol = pol; mon_cpha = pha; mon_cnt = 0; mon_sh = 8'h00;
            mon_en = 1'b1;
            pulse(0, tx);
            check("R3 nss low", nss_o, 1'b0);
            n = 0;
            while (status[7] && n < 5000) begin
                n++;
                @(negedge clk);
            end
            mon_en = 1'b0;
            check("R3 busy length", n, 16 * (dv + 1));
            check("R3 nss released", nss_o, 1'b1);
            check("R5 loopback byte", rx_data, tx);
            check("R4 mosi bits", mon_sh, tx);
            check("R4 capture edges", mon_cnt, 8);
            check("R4 idle after", sck_o, pol);
            check("R7 master flags", status[1:0], 2'b11);
        end

        // R6 write collision and R2 frozen configuration
        set_cfg(1'b1, 1'b0, 1'b0);
        pulse(2, 8'd3);
        pulse(0, 8'h96);
        idle(3);
        pulse(0, 8'h11);
        check("R6 wcol set", wcol, 1'b1);
        pulse(1, 8'h70);
        check("R2 cfg ignored while busy", status[6:4], 3'b100);
        while (status[7]) @(negedge clk);
        check("R6 write discarded", rx_data, 8'h96);
        check("R6 wcol sticky", wcol, 1'b1);
        set_cfg(1'b1, 1'b0, 1'b0);
        check("R6 wcol cleared", wcol, 1'b0);

        // R10 short select glitch is rejected, raw bit follows
        set_cfg(1'b0, 1'b0, 1'b0);
        loop_en = 1'b0;
        @(negedge clk);
        nss_i = 1'b0;
        @(negedge clk);
        check("R10 raw low", status[2], 1'b0);
        @(negedge clk);
        nss_i = 1'b1;
        idle(10);
        check("R10 glitch rejected", status[3], 1'b0);

        // slave transfers under both phases
        for (int m = 0; m < 2; m++) begin
            logic       pol, pha;
            logic [7:0] txb, mob;
            pol = m[0]; pha = m[0];
            txb = (m == 0) ? 8'hC3 : 8'h2D;
            mob = (m == 0) ? 8'h5A : 8'hB4;
            sck_i = pol;
            set_cfg(1'b0, pha, pol);
            pulse(0, txb);
            idle(3);
            check("R9 shift reg loaded", status[1], 1'b0);
            nss_i = 1'b0;
            idle(10);
            check("R10 selected", status[3], 1'b1);
            check("R11 idle before frame", status[7], 1'b0);
            slave_xfer(mob, pol, pha, got, mb);
            idle(8);
            check("R11 busy mid frame", mb, 1'b1);
            check("R11 busy cleared", status[7], 1'b0);
            check("R9 miso byte", got, txb);
            check("R8 rx byte", rx_data, mob);
            check("R8 rx not empty", status[0], 1'b0);
            check("R9 shift reg empty", status[1], 1'b1);
            pulse(3, 8'h00);
            check("R8 rx empty after read", status[0], 1'b1);
            nss_i = 1'b1;
            idle(10);
            check("R10 deselected", status[3], 1'b0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule